// File: doc/BRIEF.md
# Configurable I/O Cell Datapath

This block models the datapath of a single configurable I/O cell in a programmable logic fabric. A set of configuration bits, all active low (a bit of 0 turns its feature on), decides how the cell behaves. Both the value driven toward the pad and the pad's drive enable come from a bank of local interconnect lines. Each is chosen by a two-dimensional select made of two one-cold groups. One group always has three entries. The other has six entries for a cell on a side edge and four entries for a cell on the top or bottom edge; a parameter chooses which.

A fast-out link from a neighbouring logic block can replace the selected data value. The cell can invert its output, drive open-drain, or work as output-only with its input path switched off. A device-wide output-enable input can tristate the pad regardless of the selected enable. Pad electrical options (slew, drive strength, Schmitt trigger, bus-hold and weak pull-up) are only decoded into status flags. Enabling bus-hold and pull-up together is reported as a clash. A select group that is not properly one-cold raises an error flag and forces the affected result to 0. All results are registered, so each appears one clock after its inputs.

Top module: `iocell_top`

## Requirements
- R1: With fast-out, invert and open-drain off, pad_out equals local line (c*ROWS + r). Here c is the position of the single 0 bit in cfg_dat_col_n and r is the position of the single 0 bit in cfg_dat_row_n. With six columns, c=2 and r=1 select line 7.
- R2: The enable select uses cfg_oe_col_n and cfg_oe_row_n with the same line mapping as R1. With open-drain off and dev_oe=1, pad_oe equals the selected line.
- R3: A select group with no 0 bit, or with more than one 0 bit, sets sel_err. A malformed data group forces pad_out to 0 while fast-out is off. A malformed enable group forces pad_oe to 0.
- R4: When cfg_fast_n=0, the output value comes from fast_in. The data select groups are then ignored and cannot raise sel_err.
- R5: When cfg_inv_n=0, a valid data value is inverted before it reaches the pad.
- R6: When dev_oe=0, pad_oe is 0 whatever the enable select gives.
- R7: When cfg_odrain_n=0, pad_out is 0 and pad_oe is high only when the enable is active and the final data value is 0.
- R8: When cfg_outonly_n=0, core_in is 0. Otherwise core_in follows pad_in.
- R9: Each status flag (stat_fast_slew, stat_low_drive, stat_schmitt, stat_bus_hold, stat_pull_up) is the inverse of its configuration bit.
- R10: stat_pull_clash is 1 exactly when cfg_hold_n and cfg_pullup_n are both 0.
- R11: While rst_n is low, every output is 0.
- R12: Every output reflects the inputs sampled at the previous rising clock edge: a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines | input | LINES | Local interconnect bank (18 for side cells, 12 for top/bottom cells) |
| fast_in | input | 1 | Fast-out value from the neighbouring logic block |
| dev_oe | input | 1 | Device-wide output enable, active high |
| pad_in | input | 1 | Value sensed at the pad |
| cfg_dat_col_n | input | COLS | One-cold column group of the data select |
| cfg_dat_row_n | input | ROWS | One-cold row group of the data select |
| cfg_oe_col_n | input | COLS | One-cold column group of the enable select |
| cfg_oe_row_n | input | ROWS | One-cold row group of the enable select |
| cfg_fast_n | input | 1 | 0 = take data from fast_in |
| cfg_inv_n | input | 1 | 0 = invert output data |
| cfg_odrain_n | input | 1 | 0 = open-drain drive |
| cfg_outonly_n | input | 1 | 0 = input path off |
| cfg_slew_n | input | 1 | 0 = fast slew |
| cfg_drive_n | input | 1 | 0 = low drive current |
| cfg_schmitt_n | input | 1 | 0 = Schmitt trigger on |
| cfg_hold_n | input | 1 | 0 = bus-hold on |
| cfg_pullup_n | input | 1 | 0 = weak pull-up on |
| pad_out | output | 1 | Registered value toward the pad |
| pad_oe | output | 1 | Registered pad drive enable |
| core_in | output | 1 | Registered input toward the fabric |
| sel_err | output | 1 | Malformed select group seen |
| stat_fast_slew | output | 1 | Fast slew flag |
| stat_low_drive | output | 1 | Low drive current flag |
| stat_schmitt | output | 1 | Schmitt trigger flag |
| stat_bus_hold | output | 1 | Bus-hold flag |
| stat_pull_up | output | 1 | Weak pull-up flag |
| stat_pull_clash | output | 1 | Bus-hold and pull-up both on |

## Verification
Every output of this cell comes from one register stage. A configuration and line pattern applied before a rising edge is therefore due on pad_out, pad_oe, core_in, sel_err and the status flags just after that edge. The bench drives new inputs on the falling edge and computes the expected values for them at that moment. It compares those values at the next falling edge, half a period after the capturing edge, so every comparison lands exactly one cycle after its stimulus. Reset values are compared while reset is still held.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  localparam int unsigned GRP_MAXW = 16;

  typedef struct packed {
    logic fast_slew;
    logic low_drive;
    logic schmitt;
    logic bus_hold;
    logic pull_up;
    logic pull_clash;
  } pad_status_t;

  // Count of zero bits among the low 'width' bits of a group
  function automatic int unsigned cold_count(logic [GRP_MAXW-1:0] grp, int unsigned width);
    int unsigned n;
    n = 0;
    for (int unsigned i = 0; i < GRP_MAXW; i++) begin
      if (i < width && !grp[i]) n++;
    end
    return n;
  endfunction

  // Position of the lowest zero bit (0 when none)
  function automatic int unsigned cold_pos(logic [GRP_MAXW-1:0] grp, int unsigned width);
    int unsigned p;
    logic found;
    p = 0;
    found = 1'b0;
    for (int unsigned i = 0; i < GRP_MAXW; i++) begin
      if (i < width && !grp[i] && !found) begin
        p = i;
        found = 1'b1;
      end
    end
    return p;
  endfunction

  // Flat line index of a column/row pair
  function automatic int unsigned line_of(int unsigned col, int unsigned row, int unsigned rows);
    return col * rows + row;
  endfunction

endpackage

// File: rtl/iocell_select.sv
module iocell_select
  import iocell_pkg::*;
#(
  parameter int ROWS  = 3,
  parameter int COLS  = 6,
  parameter int LINES = ROWS * COLS
) (
  input  logic [LINES-1:0] lines,
  input  logic [COLS-1:0]  col_n,
  input  logic [ROWS-1:0]  row_n,
  output logic             value,
  output logic             err
);

  logic [GRP_MAXW-1:0] col_w, row_w;
  int unsigned col_zeros, row_zeros, col_idx, row_idx, line_idx;
  logic groups_ok;

  always_comb begin
    col_w = '1;
    row_w = '1;
    col_w[COLS-1:0] = col_n;
    row_w[ROWS-1:0] = row_n;
    col_zeros = cold_count(col_w, COLS);
    row_zeros = cold_count(row_w, ROWS);
    col_idx   = cold_pos(col_w, COLS);
    row_idx   = cold_pos(row_w, ROWS);
    line_idx  = line_of(col_idx, row_idx, ROWS);
    groups_ok = (col_zeros == 1) && (row_zeros == 1);
    err       = !groups_ok;
    value     = 1'b0;
    if (groups_ok && line_idx < LINES) value = lines[line_idx];
  end

  // R3: a malformed group never lets a line through
  always_comb begin
    if (err) assert_bad_group_zero_R3: assert (value == 1'b0);
  end

endmodule

// File: rtl/iocell_drive.sv
module iocell_drive (
  input  logic dat_val,
  input  logic dat_err,
  input  logic oe_val,
  input  logic oe_err,
  input  logic fast_in,
  input  logic dev_oe,
  input  logic cfg_fast_n,
  input  logic cfg_inv_n,
  input  logic cfg_odrain_n,
  output logic nxt_out,
  output logic nxt_oe,
  output logic nxt_err
);

  logic use_fast, dat_bad, raw_val, final_val, en_val;

  always_comb begin
    use_fast  = !cfg_fast_n;
    dat_bad   = dat_err && !use_fast;
    raw_val   = use_fast ? fast_in : dat_val;
    final_val = dat_bad ? 1'b0 : (raw_val ^ !cfg_inv_n);
    en_val    = oe_val && !oe_err && dev_oe;
    if (!cfg_odrain_n) begin
      nxt_out = 1'b0;
      nxt_oe  = en_val && !final_val;
    end else begin
      nxt_out = final_val;
      nxt_oe  = en_val;
    end
    nxt_err = dat_bad || oe_err;
  end

endmodule

// File: rtl/iocell_status.sv
module iocell_status
  import iocell_pkg::*;
(
  input  logic        pad_in,
  input  logic        cfg_outonly_n,
  input  logic        cfg_slew_n,
  input  logic        cfg_drive_n,
  input  logic        cfg_schmitt_n,
  input  logic        cfg_hold_n,
  input  logic        cfg_pullup_n,
  output logic        nxt_core_in,
  output pad_status_t nxt_status
);

  always_comb begin
    nxt_core_in           = cfg_outonly_n ? pad_in : 1'b0;
    nxt_status.fast_slew  = !cfg_slew_n;
    nxt_status.low_drive  = !cfg_drive_n;
    nxt_status.schmitt    = !cfg_schmitt_n;
    nxt_status.bus_hold   = !cfg_hold_n;
    nxt_status.pull_up    = !cfg_pullup_n;
    nxt_status.pull_clash = !cfg_hold_n && !cfg_pullup_n;
  end

endmodule

// File: rtl/iocell_top.sv
module iocell_top
  import iocell_pkg::*;
#(
  parameter bit SIDE_CELL = 1'b1,
  parameter int ROWS      = 3,
  parameter int COLS_SIDE = 6,
  parameter int COLS_TB   = 4,
  localparam int COLS     = SIDE_CELL ? COLS_SIDE : COLS_TB,
  localparam int LINES    = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines,
  input  logic             fast_in,
  input  logic             dev_oe,
  input  logic             pad_in,
  input  logic [COLS-1:0]  cfg_dat_col_n,
  input  logic [ROWS-1:0]  cfg_dat_row_n,
  input  logic [COLS-1:0]  cfg_oe_col_n,
  input  logic [ROWS-1:0]  cfg_oe_row_n,
  input  logic             cfg_fast_n,
  input  logic             cfg_inv_n,
  input  logic             cfg_odrain_n,
  input  logic             cfg_outonly_n,
  input  logic             cfg_slew_n,
  input  logic             cfg_drive_n,
  input  logic             cfg_schmitt_n,
  input  logic             cfg_hold_n,
  input  logic             cfg_pullup_n,
  output logic             pad_out,
  output logic             pad_oe,
  output logic             core_in,
  output logic             sel_err,
  output logic             stat_fast_slew,
  output logic             stat_low_drive,
  output logic             stat_schmitt,
  output logic             stat_bus_hold,
  output logic             stat_pull_up,
  output logic             stat_pull_clash
);

  // Named internal events
  logic        dat_val, dat_err, oe_val, oe_err;
  logic        nxt_out, nxt_oe, nxt_err, nxt_core_in;
  pad_status_t nxt_status, status_q;

  iocell_select #(.ROWS(ROWS), .COLS(COLS), .LINES(LINES)) u_dat_sel (
    .lines (lines),
    .col_n (cfg_dat_col_n),
    .row_n (cfg_dat_row_n),
    .value (dat_val),
    .err   (dat_err)
  );

  iocell_select #(.ROWS(ROWS), .COLS(COLS), .LINES(LINES)) u_oe_sel (
    .lines (lines),
    .col_n (cfg_oe_col_n),
    .row_n (cfg_oe_row_n),
    .value (oe_val),
    .err   (oe_err)
  );

  iocell_drive u_drive (
    .dat_val      (dat_val),
    .dat_err      (dat_err),
    .oe_val       (oe_val),
    .oe_err       (oe_err),
    .fast_in      (fast_in),
    .dev_oe       (dev_oe),
    .cfg_fast_n   (cfg_fast_n),
    .cfg_inv_n    (cfg_inv_n),
    .cfg_odrain_n (cfg_odrain_n),
    .nxt_out      (nxt_out),
    .nxt_oe       (nxt_oe),
    .nxt_err      (nxt_err)
  );

  iocell_status u_status (
    .pad_in        (pad_in),
    .cfg_outonly_n (cfg_outonly_n),
    .cfg_slew_n    (cfg_slew_n),
    .cfg_drive_n   (cfg_drive_n),
    .cfg_schmitt_n (cfg_schmitt_n),
    .cfg_hold_n    (cfg_hold_n),
    .cfg_pullup_n  (cfg_pullup_n),
    .nxt_core_in   (nxt_core_in),
    .nxt_status    (nxt_status)
  );

  // R12: single register stage for every result
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_out  <= 1'b0;
      pad_oe   <= 1'b0;
      core_in  <= 1'b0;
      sel_err  <= 1'b0;
      status_q <= '0;
    end else begin
      pad_out  <= nxt_out;
      pad_oe   <= nxt_oe;
      core_in  <= nxt_core_in;
      sel_err  <= nxt_err;
      status_q <= nxt_status;
    end
  end

  assign stat_fast_slew  = status_q.fast_slew;
  assign stat_low_drive  = status_q.low_drive;
  assign stat_schmitt    = status_q.schmitt;
  assign stat_bus_hold   = status_q.bus_hold;
  assign stat_pull_up    = status_q.pull_up;
  assign stat_pull_clash = status_q.pull_clash;

  assert_dev_oe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_oe |=> !pad_oe);

  assert_odrain_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_odrain_n |=> !pad_out);

  assert_outonly_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_outonly_n |=> !core_in);

  assert_pull_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hold_n && !cfg_pullup_n) |=> (stat_pull_clash && stat_bus_hold && stat_pull_up));

  assert_bad_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_err && cfg_fast_n) |=> (sel_err && !pad_out));

  assert_bad_oe_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    oe_err |=> (sel_err && !pad_oe));

  assert_fast_no_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fast_n && !oe_err) |=> !sel_err);

endmodule

// File: tb/sim_iocell_top.sv
module sim_iocell_top;
  localparam int CLK_PERIOD = 10;
  localparam bit SIDE_CELL  = 1'b1;
  localparam int ROWS       = 3;
  localparam int COLS       = SIDE_CELL ? 6 : 4;
  localparam int LINES      = ROWS * COLS;
  localparam int N_RANDOM   = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] lines = '0;
  logic fast_in = 0, dev_oe = 0, pad_in = 0;
  logic [COLS-1:0] cfg_dat_col_n = '1, cfg_oe_col_n = '1;
  logic [ROWS-1:0] cfg_dat_row_n = '1, cfg_oe_row_n = '1;
  logic cfg_fast_n = 1, cfg_inv_n = 1, cfg_odrain_n = 1, cfg_outonly_n = 1;
  logic cfg_slew_n = 1, cfg_drive_n = 1, cfg_schmitt_n = 1, cfg_hold_n = 1, cfg_pullup_n = 1;
  logic pad_out, pad_oe, core_in, sel_err;
  logic stat_fast_slew, stat_low_drive, stat_schmitt, stat_bus_hold, stat_pull_up, stat_pull_clash;

  int n_checks = 0;
  int n_fail = 0;

  // expected values for the pattern currently applied
  logic e_out, e_oe, e_core, e_err;
  logic [5:0] e_stat;
  string t_out, t_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  iocell_top #(.SIDE_CELL(SIDE_CELL), .ROWS(ROWS)) u0 (
    .clk(clk), .rst_n(rst_n), .lines(lines), .fast_in(fast_in), .dev_oe(dev_oe),
    .pad_in(pad_in), .cfg_dat_col_n(cfg_dat_col_n), .cfg_dat_row_n(cfg_dat_row_n),
    .cfg_oe_col_n(cfg_oe_col_n), .cfg_oe_row_n(cfg_oe_row_n), .cfg_fast_n(cfg_fast_n),
    .cfg_inv_n(cfg_inv_n), .cfg_odrain_n(cfg_odrain_n), .cfg_outonly_n(cfg_outonly_n),
    .cfg_slew_n(cfg_slew_n), .cfg_drive_n(cfg_drive_n), .cfg_schmitt_n(cfg_schmitt_n),
    .cfg_hold_n(cfg_hold_n), .cfg_pullup_n(cfg_pullup_n), .pad_out(pad_out),
    .pad_oe(pad_oe), .core_in(core_in), .sel_err(sel_err),
    .stat_fast_slew(stat_fast_slew), .stat_low_drive(stat_low_drive),
    .stat_schmitt(stat_schmitt), .stat_bus_hold(stat_bus_hold),
    .stat_pull_up(stat_pull_up), .stat_pull_clash(stat_pull_clash)
  );

  task automatic check(input string req, input string what, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // Bench model of a two-group select: returns {ok, value}
  function automatic logic [1:0] pick(input logic [COLS-1:0] c, input logic [ROWS-1:0] r,
                                      input logic [LINES-1:0] ln);
    int zc = 0, zr = 0, pc = 0, pr = 0;
    for (int i = COLS-1; i >= 0; i--) if (c[i] == 1'b0) begin zc++; pc = i; end
    for (int i = ROWS-1; i >= 0; i--) if (r[i] == 1'b0) begin zr++; pr = i; end
    if (zc != 1 || zr != 1) return 2'b00;
    return {1'b1, ln[pc*ROWS + pr]};
  endfunction

  task automatic predict();
    logic [1:0] d, o;
    logic v, en;
    d = pick(cfg_dat_col_n, cfg_dat_row_n, lines);
    o = pick(cfg_oe_col_n, cfg_oe_row_n, lines);
    if (!cfg_fast_n) begin v = fast_in ^ ~cfg_inv_n; t_out = "R4"; end
    else if (!d[1])  begin v = 1'b0; t_out = "R3"; end
    else begin v = d[0] ^ ~cfg_inv_n; t_out = cfg_inv_n ? "R1" : "R5"; end
    en = o[1] & o[0] & dev_oe;
    t_oe = !dev_oe ? "R6" : (!o[1] ? "R3" : "R2");
    if (!cfg_odrain_n) begin
      e_out = 1'b0; e_oe = en & ~v; t_out = "R7"; t_oe = "R7";
    end else begin
      e_out = v; e_oe = en;
    end
    e_err  = (cfg_fast_n & ~d[1]) | ~o[1];
    e_core = cfg_outonly_n ? pad_in : 1'b0;
    e_stat = {~cfg_slew_n, ~cfg_drive_n, ~cfg_schmitt_n, ~cfg_hold_n, ~cfg_pullup_n,
              ~cfg_hold_n & ~cfg_pullup_n};
  endtask

  task automatic compare_all();
    check(t_out, "pad_out (R12 one cycle)", {5'b0, pad_out}, {5'b0, e_out});
    check(t_oe, "pad_oe", {5'b0, pad_oe}, {5'b0, e_oe});
    check("R8", "core_in", {5'b0, core_in}, {5'b0, e_core});
    check("R3", "sel_err", {5'b0, sel_err}, {5'b0, e_err});
    check("R9", "status flags", {stat_fast_slew, stat_low_drive, stat_schmitt,
          stat_bus_hold, stat_pull_up, 1'b0}, {e_stat[5:1], 1'b0});
    check("R10", "pull clash", {5'b0, stat_pull_clash}, {5'b0, e_stat[0]});
  endtask

  function automatic logic [COLS-1:0] cold_col(input int unsigned k);
    logic [COLS-1:0] g = '1;
    g[k % COLS] = 1'b0;
    return g;
  endfunction

  function automatic logic [ROWS-1:0] cold_row(input int unsigned k);
    logic [ROWS-1:0] g = '1;
    g[k % ROWS] = 1'b0;
    return g;
  endfunction

  // apply at falling edge, compare at the next falling edge
  task automatic step();
    predict();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R11: reset values
    @(negedge clk);
    cfg_slew_n = 0; cfg_hold_n = 0; cfg_pullup_n = 0; pad_in = 1; dev_oe = 1;
    @(negedge clk);
    check("R11", "reset outputs", {pad_out, pad_oe, core_in, sel_err, stat_bus_hold, stat_pull_clash}, 6'b0);
    rst_n = 1'b1;
    cfg_slew_n = 1; cfg_hold_n = 1; cfg_pullup_n = 1;

    // R1: column 2, row 1 selects line 7
    lines = '0; lines[7] = 1'b1;
    cfg_dat_col_n = cold_col(2); cfg_dat_row_n = cold_row(1);
    cfg_oe_col_n = cold_col(2); cfg_oe_row_n = cold_row(1);
    step();
    check("R1", "line 7 directed", {4'b0, pad_out, pad_oe}, 6'b000011);
    lines = ~lines;
    step();
    // R3: no zero and two zeros
    cfg_dat_col_n = '1; lines = '1;
    step();
    cfg_dat_col_n = cold_col(0) & cold_col(1);
    step();
    // R4: fast-out ignores a malformed data group
    cfg_fast_n = 0; fast_in = 1;
    step();
    fast_in = 0;
    step();
    // R5 invert, R6 device enable off, R7 open-drain
    cfg_fast_n = 1; cfg_dat_col_n = cold_col(3); cfg_inv_n = 0;
    step();
    dev_oe = 0;
    step();
    dev_oe = 1; cfg_odrain_n = 0; lines = '0;
    step();
    // R8 output-only, R10 clash
    cfg_odrain_n = 1; cfg_inv_n = 1; cfg_outonly_n = 0; pad_in = 1;
    cfg_hold_n = 0; cfg_pullup_n = 0;
    step();
    cfg_outonly_n = 1; cfg_pullup_n = 1;
    step();

    for (int n = 0; n < N_RANDOM; n++) begin
      for (int i = 0; i < LINES; i++) lines[i] = $urandom_range(0, 1);
      fast_in = $urandom_range(0, 1);
      dev_oe  = ($urandom_range(0, 7) != 0);
      pad_in  = $urandom_range(0, 1);
      cfg_dat_col_n = ($urandom_range(0, 9) == 0) ? COLS'($urandom) : cold_col($urandom);
      cfg_dat_row_n = ($urandom_range(0, 9) == 0) ? ROWS'($urandom) : cold_row($urandom);
      cfg_oe_col_n  = ($urandom_range(0, 9) == 0) ? COLS'($urandom) : cold_col($urandom);
      cfg_oe_row_n  = ($urandom_range(0, 9) == 0) ? ROWS'($urandom) : cold_row($urandom);
      cfg_fast_n    = ($urandom_range(0, 3) != 0);
      cfg_inv_n     = $urandom_range(0, 1);
      cfg_odrain_n  = ($urandom_range(0, 3) != 0);
      cfg_outonly_n = $urandom_range(0, 1);
      cfg_slew_n    = $urandom_range(0, 1);
      cfg_drive_n   = $urandom_range(0, 1);
      cfg_schmitt_n = $urandom_range(0, 1);
      cfg_hold_n    = $urandom_range(0, 1);
      cfg_pullup_n  = $urandom_range(0, 1);
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule